// File: doc/BRIEF.md
# IDE DMA Transfer Progress Tracker

This block sits between a descriptor-driven channel DMA engine and a simple request/response storage port. It follows one disk or packet (ATAPI-style) command while the engine hands it buffer chunks. For each non-empty chunk it issues one storage request. The request carries a 512-byte sector address, the buffer address and the byte count. When the response comes back, the block brings the command's task-file state up to date before it looks at the next chunk.

There are two modes. Disk mode counts whole 512-byte sectors and rounds any partial sector up. Packet mode keeps a byte position inside a 2048-byte block and converts that position into a 512-byte sector address. When a command finishes, the block sets the drive status and raises the drive interrupt. It tells the engine when a DMA run ends. A failed response, or a missing medium, is reported as a coded error.

A command is loaded with `cmd_load`. Each DMA run is then launched with `run_start`. The engine keeps `desc_addr`/`desc_len` showing the current descriptor, and steps to the next one when `desc_pop` pulses.

Top module: `ide_dma_tracker`

## Requirements
- R1: After reset, status is 0x00, irq, busy, req_valid, dma_end, err_valid and cmd_ok are low, and tf_lba, tf_count and pkt_index are zero.
- R2: A cmd_load pulse loads tf_lba, tf_count and pkt_left from the command inputs, clears pkt_index to zero, sets status to 0x80 and clears irq.
- R3: In disk mode, each successful chunk of B bytes adds ceil(B/512) to tf_lba and subtracts the same amount from tf_count.
- R4: In disk mode, whenever an update pass leaves tf_count at zero, status becomes 0x50 and irq goes high.
- R5: In packet mode, each successful chunk of B bytes is added to the byte position lba*2048 + pkt_index. tf_lba and pkt_index are then that position divided by 2048 and its remainder. pkt_left is reduced by B.
- R6: In packet mode, whenever an update pass leaves pkt_left zero or negative (two's complement), cmd_ok pulses, status becomes 0x50 and irq goes high.
- R7: A request carries req_sector equal to the current LBA in disk mode, or lba*4 + pkt_index/512 in packet mode. req_bytes equals the descriptor length and req_addr equals the descriptor address.
- R8: If the offered descriptor length is zero, dma_end pulses and no request is issued. Otherwise desc_pop pulses with desc_next_addr = desc_addr + desc_len.
- R9: The first pass of every run makes no task-file update.
- R10: In disk mode, req_write follows the command's write bit. In packet mode, req_write is always 0 (read).
- R11: An error response leaves the task file unchanged. It pulses err_valid with err_code = rsp_code and err_kind 1 (disk) or 2 (packet), pulses dma_end and returns to idle.
- R12: If media_present is low when a request would be issued, no request goes out. A packet command reports err_kind 3 with err_code 0x3A; a disk command reports err_kind 1 with err_code 0xFF. dma_end pulses in both cases.
- R13: busy is high from the issue of a request until its response. After flush_req, flush_done pulses only once busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_load | input | 1 | Load a new command into the task file |
| cmd_packet | input | 1 | 1 = packet mode, 0 = disk mode |
| cmd_write | input | 1 | Disk direction, 1 = write |
| cmd_lba | input | LBA_W | Starting LBA (sectors in disk mode, 2048-byte blocks in packet mode) |
| cmd_count | input | CNT_W | Disk sectors remaining |
| cmd_pkt_bytes | input | PKT_W | Packet bytes remaining |
| run_start | input | 1 | Start one DMA run |
| desc_addr | input | ADDR_W | Current descriptor buffer address |
| desc_len | input | LEN_W | Current descriptor byte length |
| desc_pop | output | 1 | Descriptor consumed |
| desc_next_addr | output | ADDR_W | Address after the consumed chunk |
| dma_end | output | 1 | DMA run finished |
| media_present | input | 1 | Storage medium available |
| req_valid | output | 1 | Storage request valid |
| req_ready | input | 1 | Storage port accepts request |
| req_write | output | 1 | Request is a write |
| req_sector | output | LBA_W+2 | Request address in 512-byte sectors |
| req_addr | output | ADDR_W | Request buffer address |
| req_bytes | output | LEN_W | Request byte count |
| rsp_valid | input | 1 | Storage response valid |
| rsp_err | input | 1 | Response reports failure |
| rsp_code | input | 8 | Failure code |
| busy | output | 1 | Request outstanding |
| flush_req | input | 1 | Ask to be told when idle |
| flush_done | output | 1 | Flush satisfied |
| tf_lba | output | LBA_W | Current LBA of the active mode |
| tf_count | output | CNT_W | Disk sectors remaining |
| pkt_left | output | PKT_W | Packet bytes remaining (signed) |
| pkt_index | output | 11 | Byte offset inside the current 2048-byte block |
| status | output | 8 | Drive status byte |
| irq | output | 1 | Drive interrupt |
| cmd_ok | output | 1 | Packet command completed |
| err_valid | output | 1 | Error reported |
| err_kind | output | 2 | 1 DMA, 2 packet I/O, 3 not ready |
| err_code | output | 8 | Error code |

## Verification
A wrong LBA, block offset or remaining count is visible at the ports on the very next request of the same run. The corrupted value shows up in req_sector within a few cycles of the response. It also shows in tf_lba, tf_count, pkt_left and pkt_index as soon as the update pass has run. A wrong remaining count also changes when irq, status and cmd_ok fire: the completion either appears one chunk early, one chunk late, or never. A sequencing fault shows up as a missing or extra dma_end or desc_pop. It can also show as a request issued against a zero-length descriptor, or as busy and flush_done disagreeing, all within the cycle that follows the offending state.

// File: rtl/ide_trk_pkg.sv
package ide_trk_pkg;

  localparam int SECTOR_SHIFT = 9;
  localparam int BLOCK_SHIFT  = 11;

  localparam logic [7:0] ST_CMD_BUSY   = 8'h80;
  localparam logic [7:0] ST_CMD_DONE   = 8'h50;
  localparam logic [7:0] CODE_NO_MEDIUM = 8'h3A;
  localparam logic [7:0] CODE_DISK_FAIL = 8'hFF;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_DMA       = 2'd1,
    ERR_PKT_IO    = 2'd2,
    ERR_NOT_READY = 2'd3
  } trk_err_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_EVAL  = 2'd1,
    S_ISSUE = 2'd2,
    S_WAIT  = 2'd3
  } trk_state_e;

endpackage

// File: rtl/trk_disk_step.sv
module trk_disk_step #(
  parameter int LBA_W = 32,
  parameter int CNT_W = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LBA_W-1:0] lba_init,
  input  logic [CNT_W-1:0] cnt_init,
  input  logic             apply,
  input  logic             commit,
  input  logic [LEN_W-1:0] bytes,
  output logic [LBA_W-1:0] lba_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [LBA_W-1:0] lba_nx,
  output logic             done_nx
);
  import ide_trk_pkg::*;

  localparam int SUM_W = LEN_W + 1;

  // whole sectors touched by a chunk, partial sector rounded up
  function automatic logic [SUM_W-1:0] sectors_of(input logic [LEN_W-1:0] b);
    logic [SUM_W-1:0] t;
    t = SUM_W'(b) + SUM_W'((1 << SECTOR_SHIFT) - 1);
    return t >> SECTOR_SHIFT;
  endfunction

  logic [SUM_W-1:0] span;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    span    = apply ? sectors_of(bytes) : '0;
    lba_nx  = lba_q + LBA_W'(span);
    cnt_nx  = cnt_q - CNT_W'(span);
    done_nx = (cnt_nx == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lba_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      lba_q <= lba_init;
      cnt_q <= cnt_init;
    end else if (commit) begin
      lba_q <= lba_nx;
      cnt_q <= cnt_nx;
    end
  end

endmodule

// File: rtl/trk_pkt_step.sv
module trk_pkt_step #(
  parameter int LBA_W = 32,
  parameter int PKT_W = 24,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LBA_W-1:0] lba_init,
  input  logic [PKT_W-1:0] left_init,
  input  logic             apply,
  input  logic             commit,
  input  logic [LEN_W-1:0] bytes,
  output logic [LBA_W-1:0] lba_q,
  output logic [ide_trk_pkg::BLOCK_SHIFT-1:0] idx_q,
  output logic [PKT_W-1:0] left_q,
  output logic [LBA_W+1:0] sector_nx,
  output logic             ok_nx
);
  import ide_trk_pkg::*;

  localparam int IDX_W = BLOCK_SHIFT;
  localparam int SUM_W = (LEN_W > IDX_W ? LEN_W : IDX_W) + 1;
  localparam int SEC_W = LBA_W + 2;

  // 512-byte sector holding a block/offset position
  function automatic logic [SEC_W-1:0] sector_of(input logic [LBA_W-1:0] blk,
                                                 input logic [IDX_W-1:0] off);
    return {blk, 2'b00} + SEC_W'(off >> SECTOR_SHIFT);
  endfunction

  logic [LEN_W-1:0] bytes_g;
  logic [SUM_W-1:0] idx_sum;
  logic [LBA_W-1:0] lba_nx;
  logic [IDX_W-1:0] idx_nx;
  logic [PKT_W-1:0] left_nx;

  always_comb begin
    bytes_g   = apply ? bytes : '0;
    idx_sum   = SUM_W'(idx_q) + SUM_W'(bytes_g);
    lba_nx    = lba_q + LBA_W'(idx_sum >> BLOCK_SHIFT);
    idx_nx    = idx_sum[IDX_W-1:0];
    left_nx   = left_q - PKT_W'(bytes_g);
    ok_nx     = left_nx[PKT_W-1] || (left_nx == '0);
    sector_nx = sector_of(lba_nx, idx_nx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lba_q  <= '0;
      idx_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      lba_q  <= lba_init;
      idx_q  <= '0;
      left_q <= left_init;
    end else if (commit) begin
      lba_q  <= lba_nx;
      idx_q  <= idx_nx;
      left_q <= left_nx;
    end
  end

endmodule

// File: rtl/trk_seq.sv
module trk_seq #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_start,
  input  logic [LEN_W-1:0] desc_len,
  input  logic             media_ok,
  input  logic             req_ready,
  input  logic             rsp_valid,
  input  logic             rsp_err,
  output logic             ev_eval,
  output logic             ev_go,
  output logic             ev_clean_end,
  output logic             ev_media_fail,
  output logic             ev_rsp_err,
  output logic             req_valid,
  output logic             busy,
  output logic [LEN_W-1:0] buf_size
);
  import ide_trk_pkg::*;

  trk_state_e st, st_nx;
  logic       desc_empty;

  always_comb begin
    desc_empty    = (desc_len == '0);
    ev_eval       = (st == S_EVAL);
    ev_clean_end  = ev_eval && desc_empty;
    ev_media_fail = ev_eval && !desc_empty && !media_ok;
    ev_go         = ev_eval && !desc_empty && media_ok;
    ev_rsp_err    = (st == S_WAIT) && rsp_valid && rsp_err;
    req_valid     = (st == S_ISSUE);
    busy          = (st == S_ISSUE) || (st == S_WAIT);

    st_nx = st;
    unique case (st)
      S_IDLE:  if (run_start) st_nx = S_EVAL;
      S_EVAL:  st_nx = ev_go ? S_ISSUE : S_IDLE;
      S_ISSUE: if (req_ready) st_nx = S_WAIT;
      S_WAIT:  if (rsp_valid) st_nx = rsp_err ? S_IDLE : S_EVAL;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      buf_size <= '0;
    end else begin
      st <= st_nx;
      if (st == S_IDLE && run_start) buf_size <= '0;
      else if (ev_go)                buf_size <= desc_len;
      else if (ev_rsp_err)           buf_size <= '0;
    end
  end

endmodule

// File: rtl/ide_dma_tracker.sv
module ide_dma_tracker #(
  parameter int LBA_W  = 32,
  parameter int CNT_W  = 16,
  parameter int PKT_W  = 24,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_load,
  input  logic              cmd_packet,
  input  logic              cmd_write,
  input  logic [LBA_W-1:0]  cmd_lba,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [PKT_W-1:0]  cmd_pkt_bytes,
  input  logic              run_start,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [LEN_W-1:0]  desc_len,
  output logic              desc_pop,
  output logic [ADDR_W-1:0] desc_next_addr,
  output logic              dma_end,
  input  logic              media_present,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [LBA_W+1:0]  req_sector,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_bytes,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [7:0]        rsp_code,
  output logic              busy,
  input  logic              flush_req,
  output logic              flush_done,
  output logic [LBA_W-1:0]  tf_lba,
  output logic [CNT_W-1:0]  tf_count,
  output logic [PKT_W-1:0]  pkt_left,
  output logic [10:0]       pkt_index,
  output logic [7:0]        status,
  output logic              irq,
  output logic              cmd_ok,
  output logic              err_valid,
  output logic [1:0]        err_kind,
  output logic [7:0]        err_code
);
  import ide_trk_pkg::*;

  localparam int SEC_W = LBA_W + 2;

  // command configuration
  logic mode_pkt;
  logic dir_write;

  // sequencer events, named for the checker
  logic             ev_eval, ev_go, ev_clean_end, ev_media_fail, ev_rsp_err;
  logic [LEN_W-1:0] buf_size;
  logic             has_progress;
  logic             finish_now;
  logic             flush_pend;

  // mode trackers
  logic [LBA_W-1:0] disk_lba_q, disk_lba_nx;
  logic [CNT_W-1:0] disk_cnt_q;
  logic             disk_done_nx;
  logic [LBA_W-1:0] pkt_lba_q;
  logic [10:0]      pkt_idx_q;
  logic [PKT_W-1:0] pkt_left_q;
  logic [SEC_W-1:0] pkt_sector_nx;
  logic             pkt_ok_nx;

  trk_seq #(.LEN_W(LEN_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_start    (run_start),
    .desc_len     (desc_len),
    .media_ok     (media_present),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .ev_eval      (ev_eval),
    .ev_go        (ev_go),
    .ev_clean_end (ev_clean_end),
    .ev_media_fail(ev_media_fail),
    .ev_rsp_err   (ev_rsp_err),
    .req_valid    (req_valid),
    .busy         (busy),
    .buf_size     (buf_size)
  );

  assign has_progress = ev_eval && (buf_size != '0);

  trk_disk_step #(.LBA_W(LBA_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_disk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cmd_load),
    .lba_init(cmd_lba),
    .cnt_init(cmd_count),
    .apply   (has_progress && !mode_pkt),
    .commit  (ev_eval && !mode_pkt),
    .bytes   (buf_size),
    .lba_q   (disk_lba_q),
    .cnt_q   (disk_cnt_q),
    .lba_nx  (disk_lba_nx),
    .done_nx (disk_done_nx)
  );

  trk_pkt_step #(.LBA_W(LBA_W), .PKT_W(PKT_W), .LEN_W(LEN_W)) u_pkt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd_load),
    .lba_init (cmd_lba),
    .left_init(cmd_pkt_bytes),
    .apply    (has_progress && mode_pkt),
    .commit   (ev_eval && mode_pkt),
    .bytes    (buf_size),
    .lba_q    (pkt_lba_q),
    .idx_q    (pkt_idx_q),
    .left_q   (pkt_left_q),
    .sector_nx(pkt_sector_nx),
    .ok_nx    (pkt_ok_nx)
  );

  assign finish_now = ev_eval && (mode_pkt ? pkt_ok_nx : disk_done_nx);

  assign tf_lba    = mode_pkt ? pkt_lba_q : disk_lba_q;
  assign tf_count  = disk_cnt_q;
  assign pkt_left  = pkt_left_q;
  assign pkt_index = pkt_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_pkt       <= 1'b0;
      dir_write      <= 1'b0;
      status         <= 8'h00;
      irq            <= 1'b0;
      cmd_ok         <= 1'b0;
      dma_end        <= 1'b0;
      desc_pop       <= 1'b0;
      desc_next_addr <= '0;
      err_valid      <= 1'b0;
      err_kind       <= ERR_NONE;
      err_code       <= 8'h00;
      req_write      <= 1'b0;
      req_sector     <= '0;
      req_addr       <= '0;
      req_bytes      <= '0;
      flush_pend     <= 1'b0;
      flush_done     <= 1'b0;
    end else begin
      cmd_ok     <= 1'b0;
      dma_end    <= 1'b0;
      desc_pop   <= 1'b0;
      err_valid  <= 1'b0;
      flush_done <= 1'b0;

      if (cmd_load) begin
        mode_pkt  <= cmd_packet;
        dir_write <= cmd_write;
        status    <= ST_CMD_BUSY;
        irq       <= 1'b0;
      end

      if (finish_now) begin
        status <= ST_CMD_DONE;
        irq    <= 1'b1;
        cmd_ok <= mode_pkt;
      end

      if (ev_clean_end) dma_end <= 1'b1;

      if (ev_go || ev_media_fail) begin
        desc_pop       <= 1'b1;
        desc_next_addr <= desc_addr + ADDR_W'(desc_len);
      end

      if (ev_go) begin
        req_write  <= !mode_pkt && dir_write;
        req_sector <= mode_pkt ? pkt_sector_nx : SEC_W'(disk_lba_nx);
        req_addr   <= desc_addr;
        req_bytes  <= desc_len;
      end

      if (ev_media_fail) begin
        err_valid <= 1'b1;
        err_kind  <= mode_pkt ? ERR_NOT_READY : ERR_DMA;
        err_code  <= mode_pkt ? CODE_NO_MEDIUM : CODE_DISK_FAIL;
        dma_end   <= 1'b1;
      end

      if (ev_rsp_err) begin
        err_valid <= 1'b1;
        err_kind  <= mode_pkt ? ERR_PKT_IO : ERR_DMA;
        err_code  <= rsp_code;
        dma_end   <= 1'b1;
      end

      if (flush_pend || flush_req) begin
        if (!busy && flush_pend) begin
          flush_done <= 1'b1;
          flush_pend <= 1'b0;
        end else begin
          flush_pend <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/trk_checker.sv
module trk_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              busy,
  input logic              dma_end,
  input logic              err_valid,
  input logic              desc_pop,
  input logic [ADDR_W-1:0] desc_next_addr,
  input logic [ADDR_W-1:0] desc_addr,
  input logic [LEN_W-1:0]  desc_len,
  input logic              flush_done,
  input logic              irq,
  input logic [7:0]        status,
  input logic              mode_pkt
);

  // R13: a request is only presented while busy
  p_busy_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);

  // R13: flush is answered only after an idle cycle
  p_flush_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> !$past(busy));

  // R8: run end never overlaps an outstanding request
  p_end_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_end |-> !busy && !req_valid);

  // R8: consumed descriptor reports the address after the chunk
  p_pop_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_pop |-> desc_next_addr == $past(desc_addr) + ADDR_W'($past(desc_len)));

  // R10: packet requests are reads
  p_pkt_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_pkt) |-> !req_write);

  // R11: an error leaves the sequencer idle
  p_err_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> !busy);

  // R4: interrupt rises together with the done status
  p_irq_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> status == 8'h50);

  // R7: a stalled request holds
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid);

endmodule

bind ide_dma_tracker trk_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_write     (req_write),
  .busy          (busy),
  .dma_end       (dma_end),
  .err_valid     (err_valid),
  .desc_pop      (desc_pop),
  .desc_next_addr(desc_next_addr),
  .desc_addr     (desc_addr),
  .desc_len      (desc_len),
  .flush_done    (flush_done),
  .irq           (irq),
  .status        (status),
  .mode_pkt      (mode_pkt)
);

// File: tb/ide_dma_tracker_test.sv
module ide_dma_tracker_test;

  localparam int LBA_W = 32, CNT_W = 16, PKT_W = 24, LEN_W = 16, ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_load = 0, cmd_packet = 0, cmd_write = 0;
  logic [LBA_W-1:0]  cmd_lba = '0;
  logic [CNT_W-1:0]  cmd_count = '0;
  logic [PKT_W-1:0]  cmd_pkt_bytes = '0;
  logic              run_start = 0;
  logic [ADDR_W-1:0] desc_addr = '0;
  logic [LEN_W-1:0]  desc_len = '0;
  logic              desc_pop, dma_end;
  logic [ADDR_W-1:0] desc_next_addr;
  logic              media_present = 1'b1;
  logic              req_valid, req_write;
  logic              req_ready = 1'b1;
  logic [LBA_W+1:0]  req_sector;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_bytes;
  logic              rsp_valid = 0, rsp_err = 0;
  logic [7:0]        rsp_code = 8'h00;
  logic              busy, flush_done;
  logic              flush_req = 0;
  logic [LBA_W-1:0]  tf_lba;
  logic [CNT_W-1:0]  tf_count;
  logic [PKT_W-1:0]  pkt_left;
  logic [10:0]       pkt_index;
  logic [7:0]        status;
  logic              irq, cmd_ok, err_valid;
  logic [1:0]        err_kind;
  logic [7:0]        err_code;

  always #5 clk = ~clk;

  ide_dma_tracker #(.LBA_W(LBA_W), .CNT_W(CNT_W), .PKT_W(PKT_W),
                    .LEN_W(LEN_W), .ADDR_W(ADDR_W)) uut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(10 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  // run observations
  int     n_req;
  longint rq_sec[4];
  int     rq_wr[4];
  int     rq_bytes[4];
  longint rq_addr[4];
  bit     ok_seen, end_seen, err_seen, fl_done_seen, fl_early;
  int     ek, ec;

  task automatic do_load(input bit pkt, input bit wr, input int lba, input int cnt);
    @(posedge clk); #1;
    cmd_load = 1; cmd_packet = pkt; cmd_write = wr;
    cmd_lba = LBA_W'(lba); cmd_count = CNT_W'(cnt); cmd_pkt_bytes = PKT_W'(cnt);
    @(posedge clk); #1;
    cmd_load = 0;
  endtask

  task automatic do_run(input int c0, input int c1, input int c2,
                        input bit err_rsp, input int dly, input bit fl);
    int chunks[3];
    int k;
    int cd;
    bit rsp_back;
    chunks[0] = c0; chunks[1] = c1; chunks[2] = c2;
    k = 0; cd = 0; rsp_back = 0;
    n_req = 0; ok_seen = 0; end_seen = 0; err_seen = 0;
    fl_done_seen = 0; fl_early = 0; ek = 0; ec = 0;
    desc_addr = 32'h0001_0000;
    desc_len  = LEN_W'(chunks[0]);
    @(posedge clk); #1; run_start = 1;
    @(posedge clk); #1; run_start = 0;
    for (int cyc = 0; cyc < 300; cyc++) begin
      @(negedge clk);
      flush_req = 0;
      if (rsp_valid) begin rsp_valid = 0; rsp_back = 1; end
      if (flush_done) begin
        fl_done_seen = 1;
        if (n_req > 0 && !rsp_back) fl_early = 1;
      end
      if (cmd_ok) ok_seen = 1;
      if (err_valid) begin err_seen = 1; ek = int'(err_kind); ec = int'(err_code); end
      if (desc_pop) begin
        desc_addr = desc_addr + ADDR_W'(desc_len);
        k++;
        desc_len = (k < 3) ? LEN_W'(chunks[k]) : '0;
      end
      if (req_valid) begin
        if (n_req < 4) begin
          rq_sec[n_req] = longint'(req_sector);
          rq_wr[n_req] = int'(req_write);
          rq_bytes[n_req] = int'(req_bytes);
          rq_addr[n_req] = longint'(req_addr);
        end
        n_req++;
        if (fl && n_req == 1) begin flush_req = 1; rsp_back = 0; end
        cd = dly + 1;
      end else if (cd > 0) begin
        cd--;
        if (cd == 0) begin rsp_valid = 1; rsp_err = err_rsp; rsp_code = 8'h5A; end
      end
      if (dma_end) begin
        end_seen = 1;
        break;
      end
    end
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      if (flush_done) fl_done_seen = 1;
    end
    rsp_err = 0;
  endtask

  typedef struct packed {
    bit pkt; bit wr;
    int lba0; int cnt0;
    int c0; int c1; int c2;
    int exp_lba; int exp_cnt; int exp_idx;
    bit exp_done;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 100, 4,    1024, 1024, 0,    104, 0,    0,    1'b1},
    '{1'b0, 1'b1, 7,   5,    700,  512,  0,    10,  2,    0,    1'b0},
    '{1'b1, 1'b0, 3,   4096, 2048, 1536, 0,    4,   512,  1536, 1'b0},
    '{1'b1, 1'b1, 0,   1000, 600,  600,  0,    0,   -200, 1200, 1'b1},
    '{1'b1, 1'b0, 10,  3000, 1500, 1500, 0,    11,  0,    952,  1'b1},
    '{1'b0, 1'b0, 0,   3,    1,    1,    1,    3,   0,    0,    1'b1}
  };

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status == 8'h00, status, 0);
    chk("R1 irq/busy/req", !irq && !busy && !req_valid, {irq, busy, req_valid}, 0);
    chk("R1 pulses", !dma_end && !err_valid && !cmd_ok, {dma_end, err_valid, cmd_ok}, 0);
    chk("R1 task file", tf_lba == 0 && tf_count == 0 && pkt_index == 0, tf_lba, 0);

    // table of runs
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      longint pos;
      longint l;
      int cnts[3];
      int nexp;
      t = VECS[v];
      cnts[0] = t.c0; cnts[1] = t.c1; cnts[2] = t.c2;
      do_load(t.pkt, t.wr, t.lba0, t.cnt0);
      @(negedge clk);
      chk("R2 loaded lba", tf_lba == LBA_W'(t.lba0), tf_lba, t.lba0);
      chk("R2 status busy", status == 8'h80 && !irq, status, 8'h80);
      do_run(t.c0, t.c1, t.c2, 0, 1, 0);
      nexp = 0;
      for (int i = 0; i < 3 && cnts[i] != 0; i++) nexp++;
      chk("R8 request count", n_req == nexp, n_req, nexp);
      chk("R8 run ends", end_seen, end_seen, 1);
      pos = longint'(t.lba0) * 2048;
      l = t.lba0;
      for (int i = 0; i < nexp && i < 4; i++) begin
        longint es;
        es = t.pkt ? pos / 512 : l;
        chk("R7 req_sector", rq_sec[i] == es, rq_sec[i], es);
        chk("R7 req_bytes", rq_bytes[i] == cnts[i], rq_bytes[i], cnts[i]);
        chk("R10 direction", rq_wr[i] == ((!t.pkt && t.wr) ? 1 : 0), rq_wr[i], (!t.pkt && t.wr) ? 1 : 0);
        pos = pos + cnts[i];
        l = l + cnts[i] / 512 + ((cnts[i] % 512 != 0) ? 1 : 0);
      end
      chk("R7 req_addr", rq_addr[0] == 64'h1_0000, rq_addr[0], 64'h1_0000);
      if (t.pkt) begin
        chk("R5 lba", tf_lba == LBA_W'(t.exp_lba), tf_lba, t.exp_lba);
        chk("R5 index", int'(pkt_index) == t.exp_idx, pkt_index, t.exp_idx);
        chk("R5 left", $signed(pkt_left) == PKT_W'(t.exp_cnt), $signed(pkt_left), t.exp_cnt);
        chk("R6 cmd_ok", ok_seen == t.exp_done, ok_seen, t.exp_done);
        chk("R6 irq", irq == t.exp_done, irq, t.exp_done);
      end else begin
        chk("R3 lba", tf_lba == LBA_W'(t.exp_lba), tf_lba, t.exp_lba);
        chk("R3 count", tf_count == CNT_W'(t.exp_cnt), tf_count, t.exp_cnt);
        chk("R4 irq", irq == t.exp_done, irq, t.exp_done);
      end
      chk("R4 status", status == (t.exp_done ? 8'h50 : 8'h80), status, t.exp_done ? 8'h50 : 8'h80);
    end

    // R8 R9: empty descriptor, no request and no update
    do_load(0, 0, 40, 6);
    do_run(0, 0, 0, 0, 0, 0);
    chk("R8 no request on empty", n_req == 0 && end_seen, n_req, 0);
    chk("R9 lba unchanged", tf_lba == 40 && tf_count == 6, tf_lba, 40);
    chk("R9 no irq", !irq, irq, 0);

    // R11 disk error response
    do_load(0, 0, 50, 8);
    do_run(1024, 512, 0, 1, 0, 0);
    chk("R11 disk kind", err_seen && ek == 1, ek, 1);
    chk("R11 code", ec == 8'h5A, ec, 8'h5A);
    chk("R11 single request", n_req == 1 && end_seen, n_req, 1);
    chk("R11 task file kept", tf_lba == 50 && tf_count == 8, tf_lba, 50);

    // R11 packet error response
    do_load(1, 0, 9, 4096);
    do_run(2048, 0, 0, 1, 0, 0);
    chk("R11 packet kind", err_seen && ek == 2, ek, 2);
    chk("R11 packet kept", tf_lba == 9 && pkt_index == 0, tf_lba, 9);

    // R12 medium absent
    media_present = 0;
    do_load(1, 0, 2, 2048);
    do_run(512, 0, 0, 0, 0, 0);
    chk("R12 packet no request", n_req == 0 && end_seen, n_req, 0);
    chk("R12 packet kind", ek == 3 && ec == 8'h3A, ek, 3);
    do_load(0, 0, 2, 2);
    do_run(512, 0, 0, 0, 0, 0);
    chk("R12 disk kind", ek == 1 && ec == 8'hFF && n_req == 0, ek, 1);
    media_present = 1;

    // R13 flush waits for the outstanding request
    do_load(0, 0, 70, 4);
    do_run(512, 0, 0, 0, 5, 1);
    chk("R13 flush not early", !fl_early, fl_early, 0);
    chk("R13 flush answered", fl_done_seen, fl_done_seen, 1);
    chk("R13 idle after run", !busy, busy, 0);
    chk("R3 single sector", tf_lba == 71 && tf_count == 3, tf_lba, 71);

    finish_run();
  end

endmodule